// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB LCD panel, together with the current pixel column and line number. All timing comes from packed configuration words that software writes over a small register bus. Horizontal quantities are given in units of eight pixels, while vertical quantities are given in whole lines. The pixel rate is set by a dot-clock enable input: the counters move only on cycles where that enable is high and the dot clock has not been halted by software.

Software starts the output by setting a run bit and then polls a two-bit power status. While the run bit is set, the status climbs by one at each frame wrap until it reaches 3. Once the run bit is cleared, it falls by one at each frame wrap until it reaches 0. Sync and data-enable are driven only while the status reads 3, so start and stop always take effect at a frame start. A self-clearing soft-reset bit returns the counters, the run bit, the dot-clock stop and the status to zero. Each sync output has its own polarity selection.

Register word addresses (bus_addr):

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Mode |
| 2 | Horizontal count |
| 3 | Horizontal sync |
| 4 | Vertical count |
| 5 | Vertical sync |
| 6 | Dot-clock stop |
| 7 | Status (read-only) |

Top module: `lcd_sync_timing`

## Requirements
- R1: On each tick (dot_en high and dot-clock stop clear), pix_x advances by 1. After the last pixel of a line it returns to 0. A line has (horizontal-count word bits [15:0]) × 8 pixels, and the horizontal-count word is at address 2.
- R2: line_y advances by 1 when pix_x wraps. After the last line of a frame it returns to 0. A frame has (vertical-count word bits [15:0]) lines, and the vertical-count word is at address 4.
- R3: de is 1 only when all three hold: the status is 3, pix_x < (address 2 bits [31:16]) × 8, and line_y < (address 4 bits [31:16]).
- R4: HSYNC is active while the status is 3 and pix_x lies in [S×8, (S+W)×8). Here S is bits [15:0] and W is bits [31:16] of the word at address 3.
- R5: VSYNC is active while the status is 3 and line_y lies in [S, S+W). Here S is bits [15:0] and W is bits [31:16] of the word at address 5.
- R6: Bit 27 of the mode word (address 1) set makes hsync active-low. Bit 28 set makes vsync active-low. A clear bit means active-high.
- R7: The status (address 7, bits [1:0]) resets to 0. When a tick wraps the frame, the status rises by 1 if control bit 0 (address 0) is set and the status is below 3. It falls by 1 if that bit is clear and the status is above 0. Otherwise it is unchanged.
- R8: While the status is not 3, de is 0 and both syncs sit at their inactive level.
- R9: Writing 1 to control bit 8 makes that bit read 1 for one cycle. At the next clock edge the bit clears itself and pix_x, line_y, the status, the run bit and the dot-clock stop are all set to 0.
- R10: Writing 1 to bit 0 at address 6 freezes both counters. Writing 0 resumes counting, and the bit reads back as written.
- R11: While dot_en is 0, pix_x and line_y hold their values.
- R12: The four timing words read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot-clock enable, one pixel per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 19 | Current pixel column |
| line_y | output | 16 | Current line |

## Verification
The effects of a tick, a register write or a frame wrap land at the rising edge that samples them. The strobes and coordinates are decoded without further registers from the counters and the status, so they change at that same edge. Register reads are combinational and valid in the same cycle as the address. The soft-reset bit is visible for exactly the one cycle between the write edge and the clearing edge. The bench steps its arithmetic model at every rising edge, applies the same write and tick rules, and compares all outputs and status reads on the falling edge, half a cycle after every change.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_HCOUNT = 3'd2,
    A_HSYNC  = 3'd3,
    A_VCOUNT = 3'd4,
    A_VSYNC  = 3'd5,
    A_CKSTOP = 3'd6,
    A_STATUS = 3'd7
  } reg_addr_e;

  localparam int BIT_RUN   = 0;
  localparam int BIT_SRST  = 8;
  localparam int BIT_HLOW  = 27;
  localparam int BIT_VLOW  = 28;
  localparam int UNIT_SHIFT = 3;

  localparam logic [1:0] PWR_OFF = 2'd0;
  localparam logic [1:0] PWR_ON  = 2'd3;

endpackage

// File: rtl/lcd_sync_regs.sv
module lcd_sync_regs
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        pwr,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              ckstop,
  output logic              soft_clr,
  output logic              hpol_low,
  output logic              vpol_low,
  output logic [CNT_W-1:0]  h_tot,
  output logic [CNT_W-1:0]  h_act,
  output logic [CNT_W-1:0]  h_sp,
  output logic [CNT_W-1:0]  h_sw,
  output logic [CNT_W-1:0]  v_tot,
  output logic [CNT_W-1:0]  v_act,
  output logic [CNT_W-1:0]  v_sp,
  output logic [CNT_W-1:0]  v_sw
);

  logic [DATA_W-1:0] hcount_q, hsync_q, vcount_q, vsync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ckstop   <= 1'b0;
      soft_clr <= 1'b0;
      hpol_low <= 1'b0;
      vpol_low <= 1'b0;
      hcount_q <= '0;
      hsync_q  <= '0;
      vcount_q <= '0;
      vsync_q  <= '0;
    end else begin
      soft_clr <= 1'b0;
      if (soft_clr) begin
        run    <= 1'b0;
        ckstop <= 1'b0;
      end
      if (we) begin
        case (addr)
          A_CTRL: begin
            run      <= wdata[BIT_RUN];
            soft_clr <= wdata[BIT_SRST];
          end
          A_MODE: begin
            hpol_low <= wdata[BIT_HLOW];
            vpol_low <= wdata[BIT_VLOW];
          end
          A_HCOUNT: hcount_q <= wdata;
          A_HSYNC:  hsync_q  <= wdata;
          A_VCOUNT: vcount_q <= wdata;
          A_VSYNC:  vsync_q  <= wdata;
          A_CKSTOP: ckstop   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign h_tot = hcount_q[CNT_W-1:0];
  assign h_act = hcount_q[DATA_W-1:CNT_W];
  assign h_sp  = hsync_q[CNT_W-1:0];
  assign h_sw  = hsync_q[DATA_W-1:CNT_W];
  assign v_tot = vcount_q[CNT_W-1:0];
  assign v_act = vcount_q[DATA_W-1:CNT_W];
  assign v_sp  = vsync_q[CNT_W-1:0];
  assign v_sw  = vsync_q[DATA_W-1:CNT_W];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[BIT_RUN]  = run;
        rdata[BIT_SRST] = soft_clr;
      end
      A_MODE: begin
        rdata[BIT_HLOW] = hpol_low;
        rdata[BIT_VLOW] = vpol_low;
      end
      A_HCOUNT: rdata = hcount_q;
      A_HSYNC:  rdata = hsync_q;
      A_VCOUNT: rdata = vcount_q;
      A_VSYNC:  rdata = vsync_q;
      A_CKSTOP: rdata[0] = ckstop;
      A_STATUS: rdata[1:0] = pwr;
      default: ;
    endcase
  end

endmodule

// File: rtl/lcd_sync_counters.sv
module lcd_sync_counters
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PX_W = CNT_W + UNIT_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] h_tot,
  input  logic [CNT_W-1:0] v_tot,
  output logic [PX_W-1:0]  x,
  output logic [CNT_W-1:0] y,
  output logic [PX_W-1:0]  h_last,
  output logic             frame_end
);

  function automatic logic [PX_W-1:0] last_pixel(input logic [CNT_W-1:0] units);
    return {units, {UNIT_SHIFT{1'b0}}} - 1'b1;
  endfunction

  logic [CNT_W-1:0] v_last;
  logic             line_end;

  assign h_last    = last_pixel(h_tot);
  assign v_last    = v_tot - 1'b1;
  assign line_end  = (x >= h_last);
  assign frame_end = line_end && (y >= v_last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x <= '0;
      y <= '0;
    end else if (tick) begin
      if (line_end) begin
        x <= '0;
        y <= (y >= v_last) ? '0 : y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_sync_power.sv
module lcd_sync_power
  import lcd_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       frame_step,
  input  logic       run,
  output logic [1:0] pwr
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pwr <= PWR_OFF;
    end else if (frame_step) begin
      if (run && pwr != PWR_ON)
        pwr <= pwr + 1'b1;
      else if (!run && pwr != PWR_OFF)
        pwr <= pwr - 1'b1;
    end
  end

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PX_W = CNT_W + UNIT_SHIFT
) (
  input  logic [PX_W-1:0]  x,
  input  logic [CNT_W-1:0] y,
  input  logic [1:0]       pwr,
  input  logic             hpol_low,
  input  logic             vpol_low,
  input  logic [CNT_W-1:0] h_act,
  input  logic [CNT_W-1:0] h_sp,
  input  logic [CNT_W-1:0] h_sw,
  input  logic [CNT_W-1:0] v_act,
  input  logic [CNT_W-1:0] v_sp,
  input  logic [CNT_W-1:0] v_sw,
  output logic             hsync,
  output logic             vsync,
  output logic             de
);

  function automatic logic [PX_W-1:0] to_px(input logic [CNT_W-1:0] units);
    return {units, {UNIT_SHIFT{1'b0}}};
  endfunction

  function automatic logic [PX_W-1:0] widen(input logic [CNT_W-1:0] v);
    return {{UNIT_SHIFT{1'b0}}, v};
  endfunction

  function automatic logic in_window(input logic [PX_W-1:0] pos,
                                     input logic [PX_W-1:0] start,
                                     input logic [PX_W-1:0] len);
    logic [PX_W:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return (pos >= start) && ({1'b0, pos} < stop);
  endfunction

  logic on, hs_act, vs_act;

  assign on     = (pwr == PWR_ON);
  assign hs_act = on && in_window(x, to_px(h_sp), to_px(h_sw));
  assign vs_act = on && in_window(widen(y), widen(v_sp), widen(v_sw));
  assign de     = on && (x < to_px(h_act)) && (y < v_act);
  assign hsync  = hs_act ^ hpol_low;
  assign vsync  = vs_act ^ vpol_low;

endmodule

// File: rtl/lcd_sync_timing.sv
module lcd_sync_timing
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DATA_W = 2 * CNT_W,
  localparam int PX_W   = CNT_W + UNIT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PX_W-1:0]   pix_x,
  output logic [CNT_W-1:0]  line_y
);

  logic             run, ckstop, soft_clr, hpol_low, vpol_low;
  logic [CNT_W-1:0] h_tot, h_act, h_sp, h_sw, v_tot, v_act, v_sp, v_sw;
  logic [1:0]       pwr;
  logic [PX_W-1:0]  h_last;
  logic             tick, frame_end, frame_step;

  assign tick       = dot_en && !ckstop;
  assign frame_step = tick && frame_end && !soft_clr;

  lcd_sync_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pwr(pwr), .rdata(bus_rdata), .run(run), .ckstop(ckstop), .soft_clr(soft_clr),
    .hpol_low(hpol_low), .vpol_low(vpol_low),
    .h_tot(h_tot), .h_act(h_act), .h_sp(h_sp), .h_sw(h_sw),
    .v_tot(v_tot), .v_act(v_act), .v_sp(v_sp), .v_sw(v_sw)
  );

  lcd_sync_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(soft_clr),
    .h_tot(h_tot), .v_tot(v_tot), .x(pix_x), .y(line_y),
    .h_last(h_last), .frame_end(frame_end)
  );

  lcd_sync_power u_pwr (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .frame_step(frame_step),
    .run(run), .pwr(pwr)
  );

  lcd_sync_decode #(.CNT_W(CNT_W)) u_dec (
    .x(pix_x), .y(line_y), .pwr(pwr), .hpol_low(hpol_low), .vpol_low(vpol_low),
    .h_act(h_act), .h_sp(h_sp), .h_sw(h_sw),
    .v_act(v_act), .v_sp(v_sp), .v_sw(v_sw),
    .hsync(hsync), .vsync(vsync), .de(de)
  );

endmodule

// File: rtl/lcd_sync_timing_chk.sv
module lcd_sync_timing_chk #(
  parameter int CNT_W = 16,
  localparam int PX_W = CNT_W + 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             soft_clr,
  input logic             frame_step,
  input logic             run,
  input logic [PX_W-1:0]  x,
  input logic [CNT_W-1:0] y,
  input logic [PX_W-1:0]  h_last,
  input logic [1:0]       pwr,
  input logic             de,
  input logic             hsync,
  input logic             vsync,
  input logic             hpol_low,
  input logic             vpol_low
);

  // R1
  a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !soft_clr && (x < h_last) |=> x == $past(x) + 1'b1);
  // R1
  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (x == h_last) |=> x == '0);
  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !soft_clr |=> $stable(x) && $stable(y));
  // R3
  a_r3_de_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> pwr == 2'd3);
  // R8
  a_r8_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    pwr != 2'd3 |-> !de && (hsync == hpol_low) && (vsync == vpol_low));
  // R7
  a_r7_pwr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_step && !soft_clr |=> $stable(pwr));
  // R7
  a_r7_pwr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_step && run && (pwr != 2'd3) |=> pwr == $past(pwr) + 1'b1);
  // R9
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (x == '0) && (y == '0) && (pwr == 2'd0) && !run);

endmodule

bind lcd_sync_timing lcd_sync_timing_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .soft_clr(soft_clr),
  .frame_step(frame_step), .run(run), .x(pix_x), .y(line_y), .h_last(h_last),
  .pwr(pwr), .de(de), .hsync(hsync), .vsync(vsync),
  .hpol_low(hpol_low), .vpol_low(vpol_low)
);

// File: tb/lcd_sync_timing_bench.sv
`timescale 1ns/1ps
module lcd_sync_timing_bench;

  localparam int HT = 4, HA = 2, HS = 3, HW = 1;
  localparam int VT = 6, VA = 3, VS = 4, VW = 1;
  localparam int FRAME = HT * 8 * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dot_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hsync, vsync, de;
  logic [18:0] pix_x;
  logic [15:0] line_y;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lcd_sync_timing u_lcd_sync_timing (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .line_y(line_y)
  );

  // arithmetic model of the requirements
  int mx, my, mp;
  bit m_run, m_ck, m_srst, m_hl, m_vl;
  logic [31:0] m_hc, m_hs, m_vc, m_vs;

  always @(posedge clk) begin
    int hl, vl;
    bit tk, nsr;
    if (!rst_n) begin
      mx = 0; my = 0; mp = 0; m_run = 0; m_ck = 0; m_srst = 0;
      m_hl = 0; m_vl = 0; m_hc = 0; m_hs = 0; m_vc = 0; m_vs = 0;
    end else begin
      hl = (int'(m_hc[15:0]) * 8 - 1) & 32'h7ffff;
      vl = (int'(m_vc[15:0]) - 1) & 32'hffff;
      tk = dot_en && !m_ck;
      if (m_srst) begin
        mx = 0; my = 0; mp = 0;
      end else if (tk) begin
        if (mx >= hl) begin
          if (my >= vl) begin
            if (m_run && mp < 3) mp = mp + 1;
            else if (!m_run && mp > 0) mp = mp - 1;
            my = 0;
          end else my = my + 1;
          mx = 0;
        end else mx = mx + 1;
      end
      nsr = 0;
      if (m_srst) begin m_run = 0; m_ck = 0; end
      if (bus_we) begin
        case (bus_addr)
          3'd0: begin m_run = bus_wdata[0]; nsr = bus_wdata[8]; end
          3'd1: begin m_hl = bus_wdata[27]; m_vl = bus_wdata[28]; end
          3'd2: m_hc = bus_wdata;
          3'd3: m_hs = bus_wdata;
          3'd4: m_vc = bus_wdata;
          3'd5: m_vs = bus_wdata;
          3'd6: m_ck = bus_wdata[0];
          default: ;
        endcase
      end
      m_srst = nsr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison on the falling edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit on, e_de, e_hs, e_vs;
      int hsp, hep;
      on   = (mp == 3);
      hsp  = int'(m_hs[15:0]) * 8;
      hep  = hsp + int'(m_hs[31:16]) * 8;
      e_de = on && (mx < int'(m_hc[31:16]) * 8) && (my < int'(m_vc[31:16]));
      e_hs = (on && mx >= hsp && mx < hep) ^ m_hl;
      e_vs = (on && my >= int'(m_vs[15:0]) &&
              my < int'(m_vs[15:0]) + int'(m_vs[31:16])) ^ m_vl;
      check(int'(pix_x) == mx, "R1 pix_x", int'(pix_x), mx);
      check(int'(line_y) == my, "R2 line_y", int'(line_y), my);
      check(de == e_de, on ? "R3 de" : "R8 de", int'(de), int'(e_de));
      check(hsync == e_hs, on ? "R4/R6 hsync" : "R8 hsync", int'(hsync), int'(e_hs));
      check(vsync == e_vs, on ? "R5/R6 vsync" : "R8 vsync", int'(vsync), int'(e_vs));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int hold_x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(pix_x == 0, "R1 reset pix_x", int'(pix_x), 0);
    check(line_y == 0, "R2 reset line_y", int'(line_y), 0);
    check(de == 0, "R3 reset de", int'(de), 0);
    check(hsync == 0 && vsync == 0, "R8 reset syncs", int'({hsync, vsync}), 0);
    rd(3'd7, v);
    check(v[1:0] == 0, "R7 reset status", int'(v[1:0]), 0);
    chk_on = 1'b1;

    wr(3'd2, {16'(HA), 16'(HT)});
    wr(3'd3, {16'(HW), 16'(HS)});
    wr(3'd4, {16'(VA), 16'(VT)});
    wr(3'd5, {16'(VW), 16'(VS)});
    rd(3'd2, v);
    check(v == {16'(HA), 16'(HT)}, "R12 hcount readback", int'(v), int'({16'(HA), 16'(HT)}));
    rd(3'd5, v);
    check(v == {16'(VW), 16'(VS)}, "R12 vsync readback", int'(v), int'({16'(VW), 16'(VS)}));

    // start, polling status frame by frame
    dot_en = 1'b1;
    wr(3'd0, 32'h1);
    for (int f = 0; f < 4; f++) begin
      repeat (FRAME) @(negedge clk);
      rd(3'd7, v);
      check(int'(v[1:0]) == mp, "R7 status while starting", int'(v[1:0]), mp);
    end
    check(v[1:0] == 2'd3, "R7 status reaches 3", int'(v[1:0]), 3);

    // inverted polarities for a frame, then back
    wr(3'd1, 32'h1800_0000);
    rd(3'd1, v);
    check(v == 32'h1800_0000, "R6 mode readback", int'(v), 32'h1800_0000);
    repeat (FRAME + 10) @(negedge clk);
    wr(3'd1, 32'h0800_0000);
    repeat (FRAME) @(negedge clk);
    wr(3'd1, 32'h0);

    // dot enable every other cycle
    for (int i = 0; i < 2 * FRAME; i++) begin
      @(negedge clk);
      dot_en = i[0];
    end
    dot_en = 1'b0;
    @(negedge clk);
    hold_x = int'(pix_x);
    repeat (20) @(negedge clk);
    check(int'(pix_x) == hold_x, "R11 hold with dot_en low", int'(pix_x), hold_x);
    dot_en = 1'b1;

    // dot clock stop
    wr(3'd6, 32'h1);
    rd(3'd6, v);
    check(v[0] == 1'b1, "R10 stop readback", int'(v[0]), 1);
    hold_x = int'(pix_x);
    repeat (40) @(negedge clk);
    check(int'(pix_x) == hold_x, "R10 frozen pix_x", int'(pix_x), hold_x);
    wr(3'd6, 32'h0);
    rd(3'd6, v);
    check(v[0] == 1'b0, "R10 restart readback", int'(v[0]), 0);
    repeat (5) @(negedge clk);

    // stop
    wr(3'd0, 32'h0);
    repeat (4 * FRAME + 4) @(negedge clk);
    rd(3'd7, v);
    check(v[1:0] == 2'd0, "R7 status back to 0", int'(v[1:0]), 0);
    check(de == 1'b0, "R8 de after stop", int'(de), 0);

    // restart and soft reset
    wr(3'd0, 32'h1);
    repeat (2 * FRAME + 37) @(negedge clk);
    wr(3'd0, 32'h100);
    bus_addr = 3'd0;
    #1;
    check(bus_rdata[8] == 1'b1, "R9 reset bit visible", int'(bus_rdata[8]), 1);
    @(negedge clk);
    #1;
    check(bus_rdata[8] == 1'b0, "R9 reset bit self-clears", int'(bus_rdata[8]), 0);
    check(bus_rdata[0] == 1'b0, "R9 run cleared", int'(bus_rdata[0]), 0);
    check(pix_x == 0 && line_y == 0, "R9 counters cleared", int'(pix_x) + int'(line_y), 0);
    rd(3'd7, v);
    check(v[1:0] == 2'd0, "R9 status cleared", int'(v[1:0]), 0);
    repeat (50) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule